// File: doc/BRIEF.md
# Temperature Window Index with Hysteresis

This block turns a stream of signed temperature samples into a bin index for a compensation table. The bins are four degrees wide. The lowest bin and the highest bin are open-ended and catch every sample beyond them. The index moves up as soon as a sample reaches the lower edge of a higher bin. It moves down only once the sample has fallen a full degree past the lower edge of the current bin. That one-degree dead band keeps the index from toggling when the temperature sits on a bin edge.

Samples arrive with a one-cycle valid strobe, typically one per conversion period. A standby input stops all tracking. The first sample after reset, and the first sample after standby ends, loads its bin directly, with no dead band applied. An auto-update disable input hands the index register to a host write port, which saturates out-of-range values. A one-cycle pulse reports every change of the index.

Top module: `lut_temp_index`

## Requirements
- R1: After reset, `lutIndex` is 0 and `indexUpdate` is 0.
- R2: The bin of a sample T (8-bit two's complement, 1 degree per LSB) is 0 for T <= -37, 35 for T >= 100, and otherwise (T+36)/4+1. Bin k from 1 to 34 spans -40+4k to -37+4k. The first accepted sample after reset or after standby loads this bin directly.
- R3: On a later accepted sample, the index rises to the sample's bin when that bin is above the current index. The switch therefore happens at the even lower edge of the new bin.
- R4: On a later accepted sample below the current bin, the index falls only when the sample is at least two degrees below the current bin's lower edge. The new index is then the bin of T+1, so the value one degree below the edge keeps the current index.
- R5: A single sample may move the index across several bins in either direction.
- R6: The index changes from a sample only on a cycle with `tempValid` high. Without a valid sample it holds.
- R7: While `standby` is 1, samples are ignored and the index holds.
- R8: While `autoOff` is 1, samples are ignored.
- R9: With `autoOff` at 1, `hostWrEn` loads `hostWrData` into the index, saturated to 35 when above 35. With `autoOff` at 0, host writes are ignored.
- R10: `indexUpdate` is high for exactly the cycle after a clock edge at which the index register changed value, and low otherwise. Writing the value already held gives no pulse.
- R11: `lutIndex` never exceeds 35.
- R12: The index and the pulse change at the first rising clock edge that samples the causing strobe, which is one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tempSample | input | 8 | Signed temperature sample, 1 degree per LSB |
| tempValid | input | 1 | One-cycle strobe marking a new sample |
| standby | input | 1 | Halts sample tracking and holds the index |
| autoOff | input | 1 | Disables automatic index updates and enables host writes |
| hostWrEn | input | 1 | Host write strobe for the index register |
| hostWrData | input | 8 | Host write value, unsigned |
| lutIndex | output | 6 | Current table index, 0 to 35 |
| indexUpdate | output | 1 | One-cycle pulse after the index changes |

## Verification
The assertions check every cycle that:
- the index stays within the table;
- the update pulse appears exactly when the register changes;
- the index holds in standby, with automatic updates off, and with no valid sample;
- an out-of-range host write lands on the top bin.

The window arithmetic itself can only be shown by the bench scenarios. This covers the even rising edges, the one-degree band on the way down, multi-bin jumps, the open end bins at -37/-38 and 99/100, and the direct load after standby that skips the band.

// File: rtl/lti_pkg.sv
package lti_pkg;

  // Load requests from the control path to the index datapath.
  typedef struct packed {
    logic takeHost;   // load saturated host value
    logic takeFresh;  // load bin of sample, no dead band
    logic takeRise;   // step up to bin of sample
    logic takeFall;   // step down to bin of sample plus dead band
  } ltiStrobe_t;

endpackage

// File: rtl/lti_ctrl.sv
module lti_ctrl
  import lti_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tempValid,
  input  logic       standby,
  input  logic       autoOff,
  input  logic       hostWrEn,
  input  logic       riseAbove,
  input  logic       fallBelow,
  output ltiStrobe_t strobe
);

  logic primed;
  logic sampleGo;

  assign sampleGo = tempValid && !standby && !autoOff;

  // primed is low until a sample has been taken since reset or standby.
  always_ff @(posedge clk) begin
    if (!rstN)          primed <= 1'b0;
    else if (standby)   primed <= 1'b0;
    else if (sampleGo)  primed <= 1'b1;
  end

  always_comb begin
    strobe           = '0;
    strobe.takeHost  = autoOff && hostWrEn;
    strobe.takeFresh = sampleGo && !primed;
    strobe.takeRise  = sampleGo && primed && riseAbove;
    strobe.takeFall  = sampleGo && primed && !riseAbove && fallBelow;
  end

endmodule

// File: rtl/lti_datapath.sv
module lti_datapath
  import lti_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int HOST_W     = 8,
  parameter int NUM_BINS   = 36,
  parameter int BIN_SHIFT  = 2,
  parameter int FIRST_EDGE = -36,
  parameter int HYST_DEG   = 1,
  parameter int IDX_W      = $clog2(NUM_BINS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [TEMP_W-1:0] tempSample,
  input  logic        [HOST_W-1:0] hostWrData,
  input  ltiStrobe_t               strobe,
  output logic                     riseAbove,
  output logic                     fallBelow,
  output logic        [IDX_W-1:0]  lutIndex,
  output logic                     indexUpdate
);

  localparam int EXT_W = TEMP_W + 2;
  localparam int BIN_W = 1 << BIN_SHIFT;
  localparam int BASE  = FIRST_EDGE - BIN_W;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_BINS - 1);
  localparam logic signed [EXT_W-1:0] BASE_EXT = EXT_W'(BASE);
  localparam logic signed [EXT_W-1:0] TOP_EXT  = EXT_W'(NUM_BINS - 1);
  localparam logic signed [EXT_W-1:0] HYST_EXT = EXT_W'(HYST_DEG);

  function automatic logic [IDX_W-1:0] winOf(input logic signed [EXT_W-1:0] t);
    logic signed [EXT_W-1:0] off;
    logic signed [EXT_W-1:0] q;
    off = t - BASE_EXT;
    q   = off >>> BIN_SHIFT;
    if (off[EXT_W-1])  return '0;
    else if (q > TOP_EXT) return TOP_IDX;
    else return q[IDX_W-1:0];
  endfunction

  logic signed [EXT_W-1:0] tExt;
  logic signed [EXT_W-1:0] tBand;
  logic        [IDX_W-1:0] riseIdx;
  logic        [IDX_W-1:0] fallIdx;
  logic        [IDX_W-1:0] hostSat;
  logic        [IDX_W-1:0] idxQ;
  logic        [IDX_W-1:0] idxNext;
  logic                    updQ;

  assign tExt    = {{2{tempSample[TEMP_W-1]}}, tempSample};
  assign tBand   = tExt + HYST_EXT;
  assign riseIdx = winOf(tExt);
  assign fallIdx = winOf(tBand);

  assign riseAbove = riseIdx > idxQ;
  assign fallBelow = fallIdx < idxQ;

  generate
    if (HOST_W > IDX_W) begin : g_hostWide
      assign hostSat = (hostWrData > HOST_W'(NUM_BINS - 1)) ? TOP_IDX
                                                             : hostWrData[IDX_W-1:0];
    end else begin : g_hostNarrow
      logic [IDX_W-1:0] hostExt;
      assign hostExt = IDX_W'(hostWrData);
      assign hostSat = (hostExt > TOP_IDX) ? TOP_IDX : hostExt;
    end
  endgenerate

  always_comb begin
    idxNext = idxQ;
    if (strobe.takeHost)                        idxNext = hostSat;
    else if (strobe.takeFresh || strobe.takeRise) idxNext = riseIdx;
    else if (strobe.takeFall)                   idxNext = fallIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      updQ <= 1'b0;
    end else begin
      idxQ <= idxNext;
      updQ <= (idxNext != idxQ);
    end
  end

  assign lutIndex    = idxQ;
  assign indexUpdate = updQ;

endmodule

// File: rtl/lut_temp_index.sv
module lut_temp_index
  import lti_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int HOST_W     = 8,
  parameter int NUM_BINS   = 36,
  parameter int BIN_SHIFT  = 2,
  parameter int FIRST_EDGE = -36,
  parameter int HYST_DEG   = 1,
  parameter int IDX_W      = $clog2(NUM_BINS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempSample,
  input  logic              tempValid,
  input  logic              standby,
  input  logic              autoOff,
  input  logic              hostWrEn,
  input  logic [HOST_W-1:0] hostWrData,
  output logic [IDX_W-1:0]  lutIndex,
  output logic              indexUpdate
);

  ltiStrobe_t strobe;
  logic       riseAbove;
  logic       fallBelow;

  lti_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tempValid (tempValid),
    .standby   (standby),
    .autoOff   (autoOff),
    .hostWrEn  (hostWrEn),
    .riseAbove (riseAbove),
    .fallBelow (fallBelow),
    .strobe    (strobe)
  );

  lti_datapath #(
    .TEMP_W     (TEMP_W),
    .HOST_W     (HOST_W),
    .NUM_BINS   (NUM_BINS),
    .BIN_SHIFT  (BIN_SHIFT),
    .FIRST_EDGE (FIRST_EDGE),
    .HYST_DEG   (HYST_DEG),
    .IDX_W      (IDX_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .tempSample  (tempSample),
    .hostWrData  (hostWrData),
    .strobe      (strobe),
    .riseAbove   (riseAbove),
    .fallBelow   (fallBelow),
    .lutIndex    (lutIndex),
    .indexUpdate (indexUpdate)
  );

endmodule

// File: rtl/lti_chk.sv
module lti_chk #(
  parameter int HOST_W   = 8,
  parameter int NUM_BINS = 36,
  parameter int IDX_W    = $clog2(NUM_BINS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              tempValid,
  input logic              standby,
  input logic              autoOff,
  input logic              hostWrEn,
  input logic [HOST_W-1:0] hostWrData,
  input logic [IDX_W-1:0]  lutIndex,
  input logic              indexUpdate
);

  localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(NUM_BINS - 1);
  localparam logic [HOST_W-1:0] TOP_HOST = HOST_W'(NUM_BINS - 1);

  logic hostGo;
  assign hostGo = autoOff && hostWrEn;

  a_r11_index_range: assert property (@(posedge clk) disable iff (!rstN)
    lutIndex <= TOP_IDX);

  a_r10_pulse_on_change: assert property (@(posedge clk) disable iff (!rstN)
    (lutIndex != $past(lutIndex)) |-> indexUpdate);

  a_r10_pulse_only_on_change: assert property (@(posedge clk) disable iff (!rstN)
    indexUpdate |-> (lutIndex != $past(lutIndex)));

  a_r7_standby_hold: assert property (@(posedge clk) disable iff (!rstN)
    (standby && !hostGo) |=> $stable(lutIndex));

  a_r8_auto_off_hold: assert property (@(posedge clk) disable iff (!rstN)
    (autoOff && !hostWrEn) |=> $stable(lutIndex));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tempValid && !hostGo) |=> $stable(lutIndex));

  a_r9_host_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (hostGo && hostWrData >= TOP_HOST) |=> (lutIndex == TOP_IDX));

endmodule

bind lut_temp_index lti_chk #(
  .HOST_W   (HOST_W),
  .NUM_BINS (NUM_BINS),
  .IDX_W    (IDX_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .tempValid   (tempValid),
  .standby     (standby),
  .autoOff     (autoOff),
  .hostWrEn    (hostWrEn),
  .hostWrData  (hostWrData),
  .lutIndex    (lutIndex),
  .indexUpdate (indexUpdate)
);

// File: tb/sim_lut_temp_index.sv
module sim_lut_temp_index;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] tempSample = '0;
  logic       tempValid = 1'b0;
  logic       standby = 1'b0;
  logic       autoOff = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [5:0] lutIndex;
  logic       indexUpdate;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lut_temp_index u0 (
    .clk         (clk),
    .rstN        (rstN),
    .tempSample  (tempSample),
    .tempValid   (tempValid),
    .standby     (standby),
    .autoOff     (autoOff),
    .hostWrEn    (hostWrEn),
    .hostWrData  (hostWrData),
    .lutIndex    (lutIndex),
    .indexUpdate (indexUpdate)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One valid sample; results checked one edge later (R12).
  task automatic sample(input int t);
    @(negedge clk);
    tempSample = 8'(t);
    tempValid  = 1'b1;
    @(negedge clk);
    tempValid  = 1'b0;
  endtask

  task automatic hostWrite(input int v);
    @(negedge clk);
    hostWrData = 8'(v);
    hostWrEn   = 1'b1;
    @(negedge clk);
    hostWrEn   = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 index", lutIndex, 0);
    chk("R1 pulse", indexUpdate, 0);
  endtask

  task automatic t_fresh;
    sample(25);
    chk("R2 fresh bin of 25", lutIndex, 16);
    chk("R12 pulse same edge", indexUpdate, 1);
    @(negedge clk);
    chk("R10 pulse one cycle", indexUpdate, 0);
  endtask

  task automatic t_rise;
    sample(27);
    chk("R3 27 stays", lutIndex, 16);
    chk("R10 no pulse on hold", indexUpdate, 0);
    sample(28);
    chk("R3 rise at even edge 28", lutIndex, 17);
    chk("R10 pulse on rise", indexUpdate, 1);
  endtask

  task automatic t_fall;
    sample(27);
    chk("R4 27 inside band", lutIndex, 17);
    sample(26);
    chk("R4 fall at 26", lutIndex, 16);
  endtask

  task automatic t_jump;
    sample(60);
    chk("R5 jump up to 60", lutIndex, 25);
    sample(0);
    chk("R5 jump down to 0", lutIndex, 10);
  endtask

  task automatic t_ends;
    sample(127);
    chk("R2 top end 127", lutIndex, 35);
    sample(99);
    chk("R4 99 inside band of top bin", lutIndex, 35);
    sample(-37);
    chk("R4 fall to -37", lutIndex, 1);
    sample(-38);
    chk("R4 fall to bottom at -38", lutIndex, 0);
    sample(-36);
    chk("R3 rise at -36", lutIndex, 1);
    sample(-128);
    chk("R2 bottom end -128", lutIndex, 0);
    sample(100);
    chk("R3 rise to top at 100", lutIndex, 35);
  endtask

  task automatic t_idle;
    @(negedge clk);
    tempSample = 8'(-50);
    repeat (3) @(negedge clk);
    chk("R6 no valid holds", lutIndex, 35);
  endtask

  task automatic t_standby;
    sample(28);
    chk("R4 drop to 28", lutIndex, 17);
    @(negedge clk);
    standby = 1'b1;
    sample(50);
    chk("R7 standby ignores", lutIndex, 17);
    chk("R7 no pulse", indexUpdate, 0);
    @(negedge clk);
    standby = 1'b0;
    sample(27);
    chk("R7 fresh load after standby", lutIndex, 16);
  endtask

  task automatic t_host;
    @(negedge clk);
    autoOff = 1'b1;
    sample(80);
    chk("R8 autoOff ignores sample", lutIndex, 16);
    hostWrite(5);
    chk("R9 host write 5", lutIndex, 5);
    chk("R10 pulse on host write", indexUpdate, 1);
    hostWrite(200);
    chk("R9 saturate 200", lutIndex, 35);
    hostWrite(35);
    chk("R10 no pulse same value", indexUpdate, 0);
    @(negedge clk);
    autoOff = 1'b0;
    hostWrite(3);
    chk("R9 host ignored when auto on", lutIndex, 35);
    sample(99);
    chk("R4 band applies after autoOff", lutIndex, 35);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_fresh();
    t_rise();
    t_fall();
    t_jump();
    t_ends();
    t_idle();
    t_standby();
    t_host();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule